// File: doc/BRIEF.md
# RTC Calendar Transfer Sequencer

This block moves a complete calendar time between a host and a serial real-time-clock chip whose registers are four bits wide. It sits above a register access master: it raises and lowers the chip-enable line itself and hands the master one register access at a time (direction, 4-bit address, 4-bit data), waiting for an acknowledge before it issues the next one. Each calendar field is a BCD byte split across two neighbouring chip registers, units first, then tens. Weekday is the one field held in a single register.

Every host transfer opens the same way. The block selects 24-hour mode in the control register and then polls the busy flag. Between polls it lowers chip-enable for a fixed gap, and it gives up after a bounded number of polls. After reset, before it takes any host request, the block checks the chip's oscillator-stop flag. If that flag is set, it clears the interrupt-interval register, issues a control write that starts a counter adjust, waits for busy to clear, and then writes a default date of 2000-01-01, 00:00:00, weekday 0.

Top module: `rtc_xfer_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `ce`, `acc_req`, `done` and `err` are low.
- R2: After reset the block reads the control register (address 0xE). If bit 1 of that register is set, it writes 0x0 to address 0x7 and 0x7 to address 0xE, then reads 0xE until bit 0 is clear. It then runs a write transfer with packed time 52'h0_00_01_01_00_00_00, which ends with a `done` pulse.
- R3: If bit 1 of the startup control read is clear, the block makes no further access and becomes idle (`busy` low) with neither `done` nor `err` pulsing.
- R4: Every transfer raises `ce`, writes 0x4 to address 0xE and then reads address 0xE.
- R5: When bit 0 of that read is 1, `ce` falls and stays low for at least GAP_NS of clock time. The block then raises `ce` again and repeats R4.
- R6: If POLL_MAX (default 100) consecutive control reads in a transfer all return busy, the block makes no field access, pulses `err` for one cycle and returns to idle.
- R7: Field accesses use addresses 0,1,2,3,4,5,8,9,A,B,C,D,6, in that order. Step k carries bits [4k+3:4k] of the packed time. The packed layout is seconds [7:0], minutes [15:8], hours [23:16], day [31:24], month [39:32], year [47:40] and weekday [51:48], so the low nibble of each field goes to its units address.
- R8: A read transfer (`host_wr`=0) assembles the returned nibbles into `rd_time` using the R7 layout and ends with a one-cycle `done` pulse, during which `rd_time` holds that result.
- R9: At the end of every transfer `ce` stays low for at least GAP_NS of clock time before `done` or `err` pulses, and before `ce` rises again.
- R10: `busy` is high from reset until the startup sequence ends, and from the accepted request until its `done` or `err`. While `busy` is high, `host_req` is ignored.
- R11: `ce` is high whenever `acc_req` is high. `acc_wr`, `acc_addr` and `acc_wdata` do not change while `acc_req` waits for `acc_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Start a transfer; taken only while idle |
| host_wr | input | 1 | 1 = write host_time to the chip, 0 = read the chip |
| host_time | input | 52 | Packed BCD time to write (R7 layout) |
| busy | output | 1 | Startup or a transfer in progress |
| done | output | 1 | One-cycle pulse: transfer finished |
| err | output | 1 | One-cycle pulse: busy poll limit reached |
| rd_time | output | 52 | Packed BCD time of the last transfer |
| ce | output | 1 | Chip enable |
| acc_req | output | 1 | Register access request, held until acknowledged |
| acc_wr | output | 1 | Access direction, 1 = write |
| acc_addr | output | 4 | Chip register address |
| acc_wdata | output | 4 | Nibble to write |
| acc_ack | input | 1 | One-cycle acknowledge from the access master |
| acc_rdata | input | 4 | Nibble read, valid with acc_ack |

## Verification
The assertions assume the access master raises `acc_ack` only while `acc_req` is high, holds it for exactly one cycle per access, and presents `acc_rdata` in that same cycle. The bench's chip model keeps to this. It answers each request after a fixed latency, at the falling edge, and drops the acknowledge one cycle later. It also pulses `host_req` only at falling edges, so it never depends on a same-edge race with the sequencer.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;
  localparam int NSTEP = 13;
  localparam int TW    = 4 * NSTEP;
  localparam logic [3:0] REG_CTL  = 4'hE;
  localparam logic [3:0] REG_IVL  = 4'h7;
  localparam logic [3:0] CTL_24H  = 4'h4;
  localparam logic [3:0] CTL_RCV  = 4'h7;
  localparam logic [3:0] IVL_OFF  = 4'h0;

  typedef enum logic [3:0] {
    S_BOOT, S_BOOT_RD, S_RCV_INT, S_RCV_CTL, S_RCV_POLL,
    S_IDLE, S_XF_CTL, S_XF_POLL, S_XF_FIELD, S_GAP
  } seq_st_t;

  typedef enum logic [2:0] {G_QUIET, G_RETRY, G_START, G_OK, G_FAIL} gap_go_t;

  // unit/tens pairs, with the calendar date registers after the weekday slot
  function automatic logic [3:0] step_addr(input logic [3:0] s);
    if (s < 4'd6)       return s;
    else if (s < 4'd12) return s + 4'd2;
    else                return 4'h6;
  endfunction
endpackage

// File: rtl/rtc_gap_timer.sv
module rtc_gap_timer #(
  parameter int GAP_CYC = 35
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int W = $clog2(GAP_CYC + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == W'(GAP_CYC - 1));

  p_expire_only_running_r9: assert property (@(posedge clk) disable iff (rst)
    expired |=> !run || cnt == W'(GAP_CYC - 1));
endmodule

// File: rtl/rtc_retry_ctr.sv
module rtc_retry_ctr #(
  parameter int MAX = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int W = $clog2(MAX + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign last = (cnt == W'(MAX - 1));

  p_retry_bound_r6: assert property (@(posedge clk) disable iff (rst)
    inc |=> cnt != '0 && cnt <= W'(MAX - 1));
endmodule

// File: rtl/rtc_xfer_seq.sv
module rtc_xfer_seq
  import rtc_seq_pkg::*;
#(
  parameter int CLK_MHZ  = 50,
  parameter int GAP_NS   = 700,
  parameter int POLL_MAX = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_req,
  input  logic          host_wr,
  input  logic [51:0]   host_time,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [51:0]   rd_time,
  output logic          ce,
  output logic          acc_req,
  output logic          acc_wr,
  output logic [3:0]    acc_addr,
  output logic [3:0]    acc_wdata,
  input  logic          acc_ack,
  input  logic [3:0]    acc_rdata
);
  localparam int GAP_CYC = (GAP_NS * CLK_MHZ + 999) / 1000;
  localparam logic [3:0] LAST_STEP = 4'(NSTEP - 1);
  localparam logic [TW-1:0] DEF_TIME = {4'h0, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  seq_st_t        state;
  gap_go_t        gap_next;
  logic           dir_wr;
  logic [3:0]     step;
  logic [TW-1:0]  xfer_time;
  logic [5:0]     idx;
  logic           got, gap_exp, rt_last, rt_clr, rt_inc;
  logic           op_act, op_wr;
  logic [3:0]     op_addr, op_data;

  assign idx     = {step, 2'b00};
  assign got     = acc_req && acc_ack;
  assign busy    = (state != S_IDLE);
  assign rd_time = xfer_time;

  rtc_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk(clk), .rst(rst), .run(state == S_GAP), .expired(gap_exp));

  assign rt_clr = (state == S_IDLE) || (state == S_RCV_CTL && got) ||
                  (state == S_RCV_POLL && got && !acc_rdata[0]);
  assign rt_inc = got && acc_rdata[0] && !rt_last &&
                  (state == S_RCV_POLL || state == S_XF_POLL);

  rtc_retry_ctr #(.MAX(POLL_MAX)) u_retry (
    .clk(clk), .rst(rst), .clr(rt_clr), .inc(rt_inc), .last(rt_last));

  // access the current state wants issued
  always_comb begin
    op_act  = 1'b1;
    op_wr   = 1'b0;
    op_addr = REG_CTL;
    op_data = 4'h0;
    unique case (state)
      S_BOOT_RD, S_RCV_POLL, S_XF_POLL: ;
      S_RCV_INT: begin op_wr = 1'b1; op_addr = REG_IVL; op_data = IVL_OFF; end
      S_RCV_CTL: begin op_wr = 1'b1; op_data = CTL_RCV; end
      S_XF_CTL:  begin op_wr = 1'b1; op_data = CTL_24H; end
      S_XF_FIELD: begin
        op_wr   = dir_wr;
        op_addr = step_addr(step);
        op_data = xfer_time[idx +: 4];
      end
      default: op_act = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_BOOT;
      gap_next  <= G_QUIET;
      ce        <= 1'b0;
      acc_req   <= 1'b0;
      acc_wr    <= 1'b0;
      acc_addr  <= 4'h0;
      acc_wdata <= 4'h0;
      done      <= 1'b0;
      err       <= 1'b0;
      dir_wr    <= 1'b0;
      step      <= 4'h0;
      xfer_time <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (op_act && !acc_req) begin
        acc_req   <= 1'b1;
        acc_wr    <= op_wr;
        acc_addr  <= op_addr;
        acc_wdata <= op_data;
      end
      if (got) acc_req <= 1'b0;

      unique case (state)
        S_BOOT: begin ce <= 1'b1; state <= S_BOOT_RD; end
        S_BOOT_RD: if (got) begin
          if (acc_rdata[1]) state <= S_RCV_INT;
          else begin ce <= 1'b0; gap_next <= G_QUIET; state <= S_GAP; end
        end
        S_RCV_INT: if (got) state <= S_RCV_CTL;
        S_RCV_CTL: if (got) state <= S_RCV_POLL;
        S_RCV_POLL: if (got) begin
          if (!acc_rdata[0]) begin
            xfer_time <= DEF_TIME;
            dir_wr    <= 1'b1;
            ce        <= 1'b0;
            gap_next  <= G_START;
            state     <= S_GAP;
          end else if (rt_last) begin
            ce <= 1'b0; gap_next <= G_FAIL; state <= S_GAP;
          end
        end
        S_IDLE: if (host_req) begin
          dir_wr    <= host_wr;
          xfer_time <= host_time;
          ce        <= 1'b1;
          state     <= S_XF_CTL;
        end
        S_XF_CTL: if (got) state <= S_XF_POLL;
        S_XF_POLL: if (got) begin
          if (!acc_rdata[0]) begin
            step  <= 4'h0;
            state <= S_XF_FIELD;
          end else begin
            ce       <= 1'b0;
            gap_next <= rt_last ? G_FAIL : G_RETRY;
            state    <= S_GAP;
          end
        end
        S_XF_FIELD: if (got) begin
          if (!dir_wr) xfer_time[idx +: 4] <= acc_rdata;
          if (step == LAST_STEP) begin
            ce <= 1'b0; gap_next <= G_OK; state <= S_GAP;
          end else step <= step + 4'h1;
        end
        S_GAP: if (gap_exp) begin
          unique case (gap_next)
            G_RETRY, G_START: begin ce <= 1'b1; state <= S_XF_CTL; end
            G_OK:   begin done <= 1'b1; state <= S_IDLE; end
            G_FAIL: begin err  <= 1'b1; state <= S_IDLE; end
            default: state <= S_IDLE;
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // assertion-only observation of chip-enable low time
  localparam int LW = $clog2(GAP_CYC + 2);
  logic [LW-1:0] ce_low;
  logic          ce_seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      ce_low  <= '0;
      ce_seen <= 1'b0;
    end else begin
      if (ce) begin
        ce_low  <= '0;
        ce_seen <= 1'b1;
      end else if (ce_low != LW'(GAP_CYC + 1)) begin
        ce_low <= ce_low + 1'b1;
      end
    end
  end

  p_ce_gap_r9: assert property (@(posedge clk) disable iff (rst)
    ($rose(ce) && ce_seen) |-> ce_low >= LW'(GAP_CYC));
  p_ce_during_req_r11: assert property (@(posedge clk) disable iff (rst)
    acc_req |-> ce);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !acc_ack) |=> acc_req && $stable(acc_addr) && $stable(acc_wr) && $stable(acc_wdata));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_err_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
  p_end_after_busy_r10: assert property (@(posedge clk) disable iff (rst)
    ($rose(done) || $rose(err)) |-> $past(busy));
endmodule

// File: tb/tb_rtc_xfer_seq.sv
module tb_rtc_xfer_seq;
  localparam int GAP = (700 * 50 + 999) / 1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0, host_wr = 1'b0;
  logic [51:0] host_time = '0;
  logic        busy, done, err, ce, acc_req, acc_wr;
  logic [51:0] rd_time;
  logic [3:0]  acc_addr, acc_wdata;
  logic        acc_ack = 1'b0;
  logic [3:0]  acc_rdata = 4'h0;

  rtc_xfer_seq dut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr), .host_time(host_time),
    .busy(busy), .done(done), .err(err), .rd_time(rd_time), .ce(ce),
    .acc_req(acc_req), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_ack(acc_ack), .acc_rdata(acc_rdata));

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0;
  int q[$];
  logic [3:0] mem [16];
  bit  stopf = 1'b0;
  int  busy_left = 0;
  int  done_cnt = 0, err_cnt = 0;
  int  amap [13] = '{0, 1, 2, 3, 4, 5, 8, 9, 10, 11, 12, 13, 6};
  bit  ended = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input int wr, input int a, input int d);
    q.push_back(wr * 256 + a * 16 + (wr != 0 ? d : 0));
  endtask

  task automatic push_xfer(input int wr, input logic [51:0] t, input int nbusy);
    for (int i = 0; i <= nbusy; i++) begin push(1, 14, 4); push(0, 14, 0); end
    for (int k = 0; k < 13; k++) push(wr, amap[k], int'((t >> (4 * k)) & 52'hF));
  endtask

  task automatic set_mem(input logic [51:0] t);
    for (int k = 0; k < 13; k++) mem[amap[k]] = 4'((t >> (4 * k)) & 52'hF);
  endtask

  function automatic logic [51:0] get_mem();
    logic [51:0] t = '0;
    for (int k = 0; k < 13; k++) t = t | (52'(mem[amap[k]]) << (4 * k));
    return t;
  endfunction

  // chip model: answers each access two cycles after it is seen
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && acc_req) begin
        automatic int w = int'(acc_wr), a = int'(acc_addr), d = int'(acc_wdata);
        automatic int g = w * 256 + a * 16 + (w != 0 ? d : 0);
        chk(ce, "R11 ce high during access", ce, 1);
        if (q.size() == 0) chk(0, "R7 unexpected access", g, 0);
        else begin
          automatic int e = q.pop_front();
          chk(g == e, "R7 access sequence", g, e);
        end
        repeat (2) @(negedge clk);
        if (w != 0) begin
          mem[a] = 4'(d);
          if (a == 14 && d == 7) stopf = 1'b0;
        end else if (a == 14) begin
          acc_rdata = {2'b00, stopf, busy_left > 0};
          if (busy_left > 0) busy_left--;
        end else acc_rdata = mem[a];
        acc_ack = 1'b1;
        @(negedge clk);
        acc_ack = 1'b0;
      end
    end
  end

  // pulse counters and chip-enable low-time monitor
  int  low_len = 0;
  bit  ce_prev = 1'b0, ce_seen = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      low_len = 0; ce_seen = 1'b0; ce_prev = 1'b0;
    end else begin
      if (done) done_cnt++;
      if (err)  err_cnt++;
      if (ce && !ce_prev && ce_seen) chk(low_len >= GAP, "R5 ce low gap before retry", low_len, GAP);
      if ((done || err) && ce_seen) chk(!ce && low_len >= GAP, "R9 ce low gap at end", low_len, GAP);
      if (ce) begin low_len = 0; ce_seen = 1'b1; end else low_len++;
      ce_prev = ce;
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic host_go(input bit wr, input logic [51:0] t);
    @(negedge clk);
    host_req = 1'b1; host_wr = wr; host_time = t;
    @(negedge clk);
    host_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    int d0, e0;
    logic [51:0] tr, tw, tx;
    for (int i = 0; i < 16; i++) mem[i] = 4'h0;
    stopf = 1'b1;
    repeat (3) @(negedge clk);
    chk(!ce && !acc_req && !done && !err, "R1 reset outputs", {ce, acc_req, done, err}, 0);
    chk(busy, "R10 busy during reset", busy, 1);
    // R2 startup recovery with default date
    push(0, 14, 0); push(1, 7, 0); push(1, 14, 7); push(0, 14, 0);
    push_xfer(1, 52'h0_00_01_01_00_00_00, 0);
    rst = 1'b0;
    chk(!ce && !acc_req && !done && !err, "R1 first cycle after reset", {ce, acc_req, done, err}, 0);
    wait_idle();
    chk(q.size() == 0, "R2 recovery sequence complete", q.size(), 0);
    chk(get_mem() == 52'h0_00_01_01_00_00_00, "R2 default date", get_mem(), 52'h0_00_01_01_00_00_00);
    chk(done_cnt == 1 && err_cnt == 0, "R2 done after default write", {done_cnt, err_cnt}, 64'h1_0000_0000);

    // R8 read transfer, plus R10 ignored request mid-transfer
    tr = 52'h3_25_12_31_23_59_58;
    set_mem(tr);
    d0 = done_cnt;
    push_xfer(0, tr, 0);
    host_go(1'b0, '0);
    repeat (20) @(negedge clk);
    host_go(1'b1, 52'h1_11_11_11_11_11_11);
    @(negedge clk);
    while (busy && !done) @(negedge clk);
    chk(done, "R8 done pulse", done, 1);
    chk(rd_time == tr, "R8 read time", rd_time, tr);
    wait_idle();
    chk(done_cnt == d0 + 1, "R8 one done", done_cnt, d0 + 1);
    chk(q.size() == 0 && !acc_req, "R10 request while busy ignored", q.size(), 0);
    chk(get_mem() == tr, "R10 chip untouched by ignored write", get_mem(), tr);

    // R5 write with two busy polls
    tw = 52'h5_99_07_15_09_30_45;
    busy_left = 2;
    d0 = done_cnt;
    push_xfer(1, tw, 2);
    host_go(1'b1, tw);
    wait_idle();
    chk(q.size() == 0, "R4 R5 retries then fields", q.size(), 0);
    chk(get_mem() == tw, "R7 written nibbles", get_mem(), tw);
    chk(done_cnt == d0 + 1, "R5 done after retries", done_cnt, d0 + 1);

    // R6 busy never clears
    busy_left = 1000;
    d0 = done_cnt; e0 = err_cnt;
    for (int i = 0; i < 100; i++) begin push(1, 14, 4); push(0, 14, 0); end
    host_go(1'b0, '0);
    wait_idle();
    chk(q.size() == 0, "R6 exactly 100 polls, no fields", q.size(), 0);
    chk(err_cnt == e0 + 1 && done_cnt == d0, "R6 err not done", {err_cnt, done_cnt}, {e0 + 1, d0});
    chk(busy_left == 900, "R6 control reads", busy_left, 900);
    busy_left = 0;

    // R3 restart without stop flag
    tx = get_mem();
    d0 = done_cnt; e0 = err_cnt;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    push(0, 14, 0);
    rst = 1'b0;
    wait_idle();
    chk(q.size() == 0 && !busy, "R3 only control read", q.size(), 0);
    chk(done_cnt == d0 && err_cnt == e0, "R3 no pulses", done_cnt, d0);
    chk(get_mem() == tx, "R3 time unchanged", get_mem(), tx);

    ended = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule